// File: doc/BRIEF.md
# Carry-Chain Timing Fault Detector

This block exercises a long ripple-carry adder as a delay probe. After a start command it repeatedly launches operand pairs into the adder and alternates between a clearing pair (both operands zero) and a sensitizing pair. The sensitizing pair is an operand whose low N bits are ones plus the constant one. The carry it produces begins at bit 0 and ripples through exactly N full-adder stages before it settles on sum bit N. The sum is registered on the next clock edge. A scoring stage then compares it with the ideal result, which has only bit N set.

Every compared capture counts as one trial, and every mismatch counts as one fault. The block reports the fault count, the trial count and whether the most recent trial failed. When the supply is clean and the clock meets timing, every path passes. Under supply stress, a late carry shows up as faults. Simulation has no physical delay, so a test input holds the captured bit N at its stale value to stand in for a carry that arrived too late.

Top module: `cc_fault_det`

## Requirements
- R1: The adder is a plain chain of WIDTH full adders (default 80, so path lengths 49, 54, 59, 64, 69 and 74 all fit). For any length N from 0 to WIDTH-1, the sensitizing pair sums to a value with only bit N set.
- R2: Reset clears fault_cnt_o, trial_cnt_o and last_err_o. A start_i pulse clears the same three outputs at the edge where it is sampled, latches len_i and begins a run.
- R3: A run launches on every edge after the start edge, alternating clear and sensitizing pairs, with the clear pair first. Each sensitizing launch is captured one edge later and scored one edge after that, adding exactly one to trial_cnt_o. A run of s edges up to and including the stop edge therefore completes floor((s-1)/2) trials.
- R4: With inject_i held low, fault_cnt_o stays zero for every length from 0 to WIDTH-1.
- R5: When inject_i is high at the capture edge of a sensitizing launch, sum bit N keeps its stale value of zero, and that trial adds one fault. inject_i has no effect at any other edge.
- R6: last_err_o is 1 when the most recently scored trial mismatched and 0 when it matched. It holds between trials.
- R7: fault_cnt_o is CNT_W bits wide (default 32) and saturates at its all-ones value. trial_cnt_o wraps.
- R8: No launch occurs at the edge where stop_i is sampled, nor at any later edge until the next start. A trial already launched still completes, and the counters then hold.
- R9: A start_i pulse during a run discards any trial that has been launched but not yet scored, and restarts from a clear launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clear results, latch length, begin run |
| stop_i | input | 1 | End launching |
| len_i | input | LEN_W (7) | Carry path length N, sampled on start |
| inject_i | input | 1 | Test input: hold captured bit N stale |
| fault_cnt_o | output | CNT_W (32) | Saturating count of mismatched trials |
| trial_cnt_o | output | TRIAL_W (32) | Count of scored trials |
| last_err_o | output | 1 | Outcome of the most recent trial |

## Verification
The adder property assumes that len_i is below WIDTH when start_i is sampled, and the random stimulus draws lengths only from that range. Values above that range are clamped in the design but are not exercised. The restart and stop properties take start_i and stop_i as single-cycle pulses. The bench drives them only as one-cycle pulses. It holds len_i steady through a run, so the latched length matches the one the bench model uses. inject_i is toggled freely on every edge, because the design must ignore it outside sensitizing captures.

// File: rtl/cc_fd_pkg.sv
package cc_fd_pkg;
  typedef enum logic {
    PH_CLEAR = 1'b0,
    PH_SENS  = 1'b1
  } launch_ph_e;
endpackage

// File: rtl/cc_ripple_add.sv
module cc_ripple_add #(
  parameter int unsigned WIDTH = 80
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o
);
  logic [WIDTH-1:0] cy;

  assign cy[0] = 1'b0;

  // one full adder per stage, carry rippled stage to stage
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ cy[i];
    if (i < WIDTH - 1) begin : g_cy
      assign cy[i+1] = (a_i[i] & b_i[i]) | (cy[i] & (a_i[i] ^ b_i[i]));
    end
  end
endmodule

// File: rtl/cc_op_gen.sv
module cc_op_gen
  import cc_fd_pkg::*;
#(
  parameter int unsigned WIDTH = 80,
  parameter int unsigned LEN_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [WIDTH-1:0] op_a_o,
  output logic [WIDTH-1:0] op_b_o,
  output logic             sens_o,
  output logic [LEN_W-1:0] len_o
);
  localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(WIDTH - 1);

  logic             run_q;
  launch_ph_e       ph_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] len_sel;
  logic [WIDTH-1:0] mask;

  assign len_sel = (len_i > LEN_MAX) ? LEN_MAX : len_i;
  assign mask    = (ONE << len_q) - ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      ph_q   <= PH_CLEAR;
      len_q  <= '0;
      sens_o <= 1'b0;
      op_a_o <= '0;
      op_b_o <= '0;
    end else if (start_i) begin
      run_q  <= 1'b1;
      ph_q   <= PH_CLEAR;
      len_q  <= len_sel;
      sens_o <= 1'b0;
      op_a_o <= '0;
      op_b_o <= '0;
    end else if (run_q && !stop_i) begin
      case (ph_q)
        PH_CLEAR: begin
          op_a_o <= '0;
          op_b_o <= '0;
          sens_o <= 1'b0;
          ph_q   <= PH_SENS;
        end
        default: begin
          op_a_o <= mask;
          op_b_o <= ONE;
          sens_o <= 1'b1;
          ph_q   <= PH_CLEAR;
        end
      endcase
    end else begin
      run_q  <= 1'b0;
      sens_o <= 1'b0;
      op_a_o <= '0;
      op_b_o <= '0;
    end
  end

  assign len_o = len_q;
endmodule

// File: rtl/cc_score.sv
module cc_score #(
  parameter int unsigned WIDTH   = 80,
  parameter int unsigned LEN_W   = 7,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned TRIAL_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               cap_i,
  input  logic [WIDTH-1:0]   sum_i,
  input  logic [LEN_W-1:0]   len_i,
  output logic [CNT_W-1:0]   fault_cnt_o,
  output logic [TRIAL_W-1:0] trial_cnt_o,
  output logic               last_err_o
);
  localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [WIDTH-1:0] expect_sum;
  logic             miss;

  assign expect_sum = ONE << len_i;
  assign miss       = (sum_i != expect_sum);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_cnt_o <= '0;
      trial_cnt_o <= '0;
      last_err_o  <= 1'b0;
    end else if (start_i) begin
      fault_cnt_o <= '0;
      trial_cnt_o <= '0;
      last_err_o  <= 1'b0;
    end else if (cap_i) begin
      trial_cnt_o <= trial_cnt_o + TRIAL_W'(1);
      last_err_o  <= miss;
      if (miss && fault_cnt_o != CNT_MAX) fault_cnt_o <= fault_cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cc_fault_det.sv
module cc_fault_det #(
  parameter int unsigned WIDTH   = 80,
  parameter int unsigned LEN_W   = $clog2(WIDTH),
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned TRIAL_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               inject_i,
  output logic [CNT_W-1:0]   fault_cnt_o,
  output logic [TRIAL_W-1:0] trial_cnt_o,
  output logic               last_err_o
);
  logic [WIDTH-1:0] op_a, op_b, add_sum, sum_d, sum_q;
  logic [LEN_W-1:0] len_q;
  logic             sens_q, cap_q;

  cc_op_gen #(.WIDTH(WIDTH), .LEN_W(LEN_W)) u_op_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .stop_i (stop_i),
    .len_i  (len_i),
    .op_a_o (op_a),
    .op_b_o (op_b),
    .sens_o (sens_q),
    .len_o  (len_q)
  );

  cc_ripple_add #(.WIDTH(WIDTH)) u_add (
    .a_i  (op_a),
    .b_i  (op_b),
    .sum_o(add_sum)
  );

  // late-carry emulation: bit N keeps its previous (cleared) value
  always_comb begin
    sum_d = add_sum;
    if (inject_i && sens_q) sum_d[len_q] = sum_q[len_q];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      cap_q <= 1'b0;
    end else begin
      sum_q <= sum_d;
      cap_q <= start_i ? 1'b0 : sens_q;
    end
  end

  cc_score #(.WIDTH(WIDTH), .LEN_W(LEN_W), .CNT_W(CNT_W), .TRIAL_W(TRIAL_W)) u_score (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .cap_i      (cap_q),
    .sum_i      (sum_q),
    .len_i      (len_q),
    .fault_cnt_o(fault_cnt_o),
    .trial_cnt_o(trial_cnt_o),
    .last_err_o (last_err_o)
  );
endmodule

// File: rtl/cc_fault_det_chk.sv
module cc_fault_det_chk #(
  parameter int unsigned WIDTH   = 80,
  parameter int unsigned LEN_W   = 7,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned TRIAL_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               stop_i,
  input logic               inject_i,
  input logic               sens_q,
  input logic               cap_q,
  input logic [WIDTH-1:0]   sum_q,
  input logic [LEN_W-1:0]   len_q,
  input logic [CNT_W-1:0]   fault_cnt_o,
  input logic [TRIAL_W-1:0] trial_cnt_o,
  input logic               last_err_o
);
  assert_sum_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sens_q && !inject_i && !start_i) |=> ($countones(sum_q) == 1 && sum_q[len_q]));

  assert_start_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (fault_cnt_o == '0 && trial_cnt_o == '0 && !last_err_o));

  assert_alternate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sens_q |=> !sens_q);

  assert_trial_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (trial_cnt_o == $past(trial_cnt_o) ||
                  trial_cnt_o == $past(trial_cnt_o) + TRIAL_W'(1)));

  assert_stale_fault_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_q && !start_i && !sum_q[len_q]) |=> last_err_o);

  assert_pass_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_q && !start_i && sum_q[len_q] && $countones(sum_q) == 1) |=> !last_err_o);

  assert_no_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> fault_cnt_o >= $past(fault_cnt_o));

  assert_stop_halts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> !sens_q);

  assert_restart_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!cap_q && !sens_q));
endmodule

bind cc_fault_det cc_fault_det_chk #(
  .WIDTH(WIDTH), .LEN_W(LEN_W), .CNT_W(CNT_W), .TRIAL_W(TRIAL_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .stop_i     (stop_i),
  .inject_i   (inject_i),
  .sens_q     (sens_q),
  .cap_q      (cap_q),
  .sum_q      (sum_q),
  .len_q      (len_q),
  .fault_cnt_o(fault_cnt_o),
  .trial_cnt_o(trial_cnt_o),
  .last_err_o (last_err_o)
);

// File: tb/sim_cc_fault_det.sv
`timescale 1ns/1ps
module sim_cc_fault_det;
  localparam int W       = 80;
  localparam int LW      = 7;
  localparam int CW      = 4;
  localparam int TW      = 16;
  localparam int FMAX    = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          stop = 1'b0;
  logic [LW-1:0] len = '0;
  logic          inject = 1'b0;
  logic [CW-1:0] fault_cnt;
  logic [TW-1:0] trial_cnt;
  logic          last_err;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  cc_fault_det #(.WIDTH(W), .LEN_W(LW), .CNT_W(CW), .TRIAL_W(TW)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .stop_i     (stop),
    .len_i      (len),
    .inject_i   (inject),
    .fault_cnt_o(fault_cnt),
    .trial_cnt_o(trial_cnt),
    .last_err_o (last_err)
  );

  task automatic check(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int exp_trials(input int s);
    return (s - 1) / 2;
  endfunction

  // mode 0: inject low, 1: inject high, 2: random per edge
  task automatic run_trial(input int n, input int s, input int mode);
    int   ef = 0;
    int   et = 0;
    int   el = 0;
    logic inj;
    @(negedge clk);
    start = 1'b1;
    len = LW'(n);
    @(negedge clk);
    start = 1'b0;
    check("R2 start clears faults", int'(fault_cnt), 0);
    check("R2 start clears trials", int'(trial_cnt), 0);
    check("R2 start clears last_err", int'(last_err), 0);
    for (int j = 1; j <= s; j++) begin
      inj = (mode == 0) ? 1'b0 : (mode == 1) ? 1'b1 : 1'($urandom % 2);
      inject = inj;
      stop = (j == s);
      if ((j % 2) == 1 && j >= 3) begin
        et++;
        if (inj && ef < FMAX) ef++;
        el = int'(inj);
      end
      @(negedge clk);
    end
    stop = 1'b0;
    inject = 1'b0;
    repeat (3) @(negedge clk);
    check($sformatf("R3 trials len=%0d s=%0d", n, s), int'(trial_cnt), exp_trials(s));
    check($sformatf("R3 model trials len=%0d", n), et, exp_trials(s));
    if (mode == 0)
      check($sformatf("R1 R4 clean faults len=%0d", n), int'(fault_cnt), 0);
    else
      check($sformatf("R5 R7 faults len=%0d mode=%0d", n, mode), int'(fault_cnt), ef);
    check($sformatf("R6 last_err len=%0d", n), int'(last_err), el);
    repeat (4) @(negedge clk);
    check("R8 trials hold after stop", int'(trial_cnt), et);
    check("R8 faults hold after stop", int'(fault_cnt), (mode == 0) ? 0 : ef);
  endtask

  task automatic restart_test();
    @(negedge clk);
    start = 1'b1;
    len = LW'(64);
    @(negedge clk);
    start = 1'b0;
    inject = 1'b1;
    for (int j = 1; j < 9; j++) @(negedge clk);
    start = 1'b1;   // sampled at edge 9, a capture edge
    @(negedge clk);
    start = 1'b0;
    check("R9 restart clears faults", int'(fault_cnt), 0);
    check("R9 restart clears trials", int'(trial_cnt), 0);
    @(negedge clk);
    check("R9 pending trial dropped", int'(trial_cnt), 0);
    check("R9 pending fault dropped", int'(fault_cnt), 0);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    inject = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 R8 no trial after early stop", int'(trial_cnt), 0);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    int lens[6];
    seed = $urandom(32'd20240917);
    lens = '{49, 54, 59, 64, 69, 74};
    repeat (3) @(negedge clk);
    check("R2 reset faults", int'(fault_cnt), 0);
    check("R2 reset trials", int'(trial_cnt), 0);
    check("R2 reset last_err", int'(last_err), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 idle no trials", int'(trial_cnt), 0);

    foreach (lens[k]) run_trial(lens[k], 10 + k, 0);
    run_trial(0, 9, 0);
    run_trial(W - 1, 12, 0);
    run_trial(74, 12, 1);
    run_trial(49, 40, 1);
    run_trial(W - 1, 3, 1);
    run_trial(59, 2, 1);
    restart_test();
    for (int r = 0; r < 20; r++) begin
      run_trial(int'($urandom % W), 3 + int'($urandom % 40), 2);
    end
    run_trial(54, 15, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule